// File: doc/BRIEF.md
# Processor Status Register Pair

This block holds the mode and condition bits of a DSP core in two packed status words. Word 0 carries the auxiliary-register pointer, the overflow flag and mode, the interrupt mask and the data page pointer. Word 1 carries the pointer buffer, the memory configuration, test/control and carry flags, sign-extension mode, and the serial-port, hold, external-flag and product-shift modes. Both words are presented whole so that a store operation can save them. Each field is also presented on its own wire for the logic that uses it.

The block takes already-decoded strobes: a restore of either word from memory, a pointer load, a page-pointer load, a mode command bus, interrupt mask commands, and flag updates from the ALU, compare and bit-test units. A restore of word 0 never changes the interrupt mask. The overflow flag is sticky. The pointer keeps a one-deep buffer whose copy rule depends on which path writes it. The block also forms the direct address by placing the page pointer above the instruction's offset bits.

Top module: `sts_pair`

## Requirements
- R1: After reset, st0_word is 16'h0600 and st1_word is 16'h07F0. Carry, sign-extension, hold, frame-sync, external flag and interrupt mask read 1. Pointer, buffer, page, overflow, overflow mode, configuration, test/control, format, transmit mode and product shift read 0.
- R2: st0_word packs, from MSB down: pointer [15:13], overflow [12], overflow mode [11], constant 1 [10], interrupt mask [9], page pointer [8:0].
- R3: st1_word packs, from MSB down: buffer [15:13], configuration [12], test/control [11], sign-extension [10], carry [9], constant 11 [8:7], hold [6], frame-sync [5], external flag [4], format [3], transmit [2], product shift [1:0]. On a restore, the constant bits ignore the data and still read 1.
- R4: A ptr_ld copies the old pointer into the buffer and loads ptr_val into the pointer. Both changes are visible one clock later.
- R5: st0_ld loads the pointer, overflow mode and page pointer from st0_data[15:13], [11] and [8:0]. It leaves the buffer and the interrupt mask unchanged.
- R6: st1_ld loads st1_data[15:13] into both the buffer and the pointer. It also loads every non-constant word-1 field from its R3 position.
- R7: The interrupt mask is set by int_ack or int_dis and cleared by int_en. Set wins when set and clear arrive in the same cycle.
- R8: The overflow flag is set by ovf_evt and holds until ovf_clr or st0_ld clears it. The st0_data overflow bit is ignored. ovf_evt wins over a clear in the same cycle.
- R9: mode_op writes mode_arg into one word-1 or overflow-mode bit: 1 overflow mode, 2 configuration, 3 sign-extension, 4 transmit, 5 external flag, 6 format, 7 hold, 8 frame-sync. Code 9 writes pm_val into product shift. Code 0 changes nothing.
- R10: c_we writes c_val to carry, and tc_we writes tc_val to test/control.
- R11: dir_addr is {page pointer, ofs} combinationally.
- R12: A restore of a word overrides mode commands, page loads and unit writes aimed at fields of that word in the same cycle.
- R13: Pointer write priority is st1_ld, then st0_ld, then ptr_ld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st0_ld | input | 1 | Restore word 0 from st0_data |
| st0_data | input | 16 | Word 0 restore data |
| st1_ld | input | 1 | Restore word 1 from st1_data |
| st1_data | input | 16 | Word 1 restore data |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_val | input | 3 | New pointer value |
| page_ld | input | 1 | Page pointer load strobe |
| page_val | input | 9 | New page pointer |
| mode_op | input | 4 | Mode command code (R9) |
| mode_arg | input | 1 | Value for single-bit mode commands |
| pm_val | input | 2 | Value for product shift command |
| ovf_evt | input | 1 | ALU overflow event |
| ovf_clr | input | 1 | Overflow clear from branch test |
| int_ack | input | 1 | Interrupt acknowledge |
| int_dis | input | 1 | Disable maskable interrupts |
| int_en | input | 1 | Enable maskable interrupts |
| tc_we | input | 1 | Test/control write strobe |
| tc_val | input | 1 | Test/control value |
| c_we | input | 1 | Carry write strobe |
| c_val | input | 1 | Carry value |
| ofs | input | 7 | Instruction direct-address offset |
| st0_word | output | 16 | Packed word 0 |
| st1_word | output | 16 | Packed word 1 |
| arp_o | output | 3 | Pointer |
| arb_o | output | 3 | Pointer buffer |
| dp_o | output | 9 | Page pointer |
| ov_o | output | 1 | Overflow flag |
| ovm_o | output | 1 | Overflow mode |
| intm_o | output | 1 | Interrupt mask |
| cnf_o | output | 1 | RAM configuration |
| tc_o | output | 1 | Test/control flag |
| sxm_o | output | 1 | Sign-extension mode |
| c_o | output | 1 | Carry |
| hm_o | output | 1 | Hold mode |
| fsm_o | output | 1 | Frame-sync mode |
| xf_o | output | 1 | External flag |
| fo_o | output | 1 | Serial format |
| txm_o | output | 1 | Transmit mode |
| pm_o | output | 2 | Product shift mode |
| dir_addr | output | 16 | Direct address |

## Verification
The bench builds the block with its defaults: a 3-bit pointer, a 9-bit page pointer and a 7-bit offset. This gives two 16-bit words and a 16-bit direct address, so every packed field sits at the position the requirements name. At this size every restore can be followed bit for bit, including the constant-one positions and the ignored overflow bit. The same defaults allow same-cycle collisions between all three pointer writers, and between restores and mode commands, to be driven and resolved.

// File: rtl/sts_pkg.sv
package sts_pkg;
    // word-1 bit positions (fixed below the pointer buffer)
    localparam int P1_CNF  = 12;
    localparam int P1_TC   = 11;
    localparam int P1_SXM  = 10;
    localparam int P1_C    = 9;
    localparam int P1_HM   = 6;
    localparam int P1_FSM  = 5;
    localparam int P1_XF   = 4;
    localparam int P1_FO   = 3;
    localparam int P1_TXM  = 2;
    localparam int P1_LOW  = 13;   // bits below the buffer field

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_OVM  = 4'd1,
        OP_CNF  = 4'd2,
        OP_SXM  = 4'd3,
        OP_TXM  = 4'd4,
        OP_XF   = 4'd5,
        OP_FO   = 4'd6,
        OP_HM   = 4'd7,
        OP_FSM  = 4'd8,
        OP_PM   = 4'd9
    } mode_op_e;

    typedef enum logic [1:0] {
        PA_HOLD,
        PA_LOAD,
        PA_REST0,
        PA_REST1
    } ptr_act_e;
endpackage

// File: rtl/sts_ptr.sv
module sts_ptr
    import sts_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld1,
    input  logic             ld0,
    input  logic             ld,
    input  logic [PTR_W-1:0] v1,
    input  logic [PTR_W-1:0] v0,
    input  logic [PTR_W-1:0] v,
    output logic [PTR_W-1:0] arp,
    output logic [PTR_W-1:0] arb
);
    ptr_act_e act;

    always_comb begin
        if (ld1)      act = PA_REST1;
        else if (ld0) act = PA_REST0;
        else if (ld)  act = PA_LOAD;
        else          act = PA_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arp <= '0;
            arb <= '0;
        end else begin
            unique case (act)
                PA_REST1: begin
                    arp <= v1;
                    arb <= v1;
                end
                PA_REST0: arp <= v0;
                PA_LOAD: begin
                    arb <= arp;
                    arp <= v;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sts_flags.sv
module sts_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ld0,
    input  logic ld1,
    input  logic d1_tc,
    input  logic d1_c,
    input  logic ovf_evt,
    input  logic ovf_clr,
    input  logic int_ack,
    input  logic int_dis,
    input  logic int_en,
    input  logic tc_we,
    input  logic tc_val,
    input  logic c_we,
    input  logic c_val,
    output logic ov,
    output logic intm,
    output logic tc,
    output logic c
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov   <= 1'b0;
            intm <= 1'b1;
            tc   <= 1'b0;
            c    <= 1'b1;
        end else begin
            if (ovf_evt)               ov <= 1'b1;
            else if (ovf_clr || ld0)   ov <= 1'b0;

            if (int_ack || int_dis)    intm <= 1'b1;
            else if (int_en)           intm <= 1'b0;

            if (ld1)                   tc <= d1_tc;
            else if (tc_we)            tc <= tc_val;

            if (ld1)                   c <= d1_c;
            else if (c_we)             c <= c_val;
        end
    end
endmodule

// File: rtl/sts_modes.sv
module sts_modes
    import sts_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld0,
    input  logic              d0_ovm,
    input  logic [PAGE_W-1:0] d0_dp,
    input  logic              ld1,
    input  logic [12:0]       d1_low,
    input  logic [3:0]        op,
    input  logic              arg,
    input  logic [1:0]        pm_arg,
    input  logic              page_ld,
    input  logic [PAGE_W-1:0] page_val,
    output logic              ovm,
    output logic [PAGE_W-1:0] dp,
    output logic              cnf,
    output logic              sxm,
    output logic              hm,
    output logic              fsm,
    output logic              xf,
    output logic              fo,
    output logic              txm,
    output logic [1:0]        pm
);
    mode_op_e cmd;
    assign cmd = mode_op_e'(op);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovm <= 1'b0;
            dp  <= '0;
        end else if (ld0) begin
            ovm <= d0_ovm;
            dp  <= d0_dp;
        end else begin
            if (cmd == OP_OVM) ovm <= arg;
            if (page_ld)       dp  <= page_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnf <= 1'b0;
            sxm <= 1'b1;
            hm  <= 1'b1;
            fsm <= 1'b1;
            xf  <= 1'b1;
            fo  <= 1'b0;
            txm <= 1'b0;
            pm  <= 2'b00;
        end else if (ld1) begin
            cnf <= d1_low[P1_CNF];
            sxm <= d1_low[P1_SXM];
            hm  <= d1_low[P1_HM];
            fsm <= d1_low[P1_FSM];
            xf  <= d1_low[P1_XF];
            fo  <= d1_low[P1_FO];
            txm <= d1_low[P1_TXM];
            pm  <= d1_low[1:0];
        end else begin
            unique case (cmd)
                OP_CNF:  cnf <= arg;
                OP_SXM:  sxm <= arg;
                OP_TXM:  txm <= arg;
                OP_XF:   xf  <= arg;
                OP_FO:   fo  <= arg;
                OP_HM:   hm  <= arg;
                OP_FSM:  fsm <= arg;
                OP_PM:   pm  <= pm_arg;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sts_pair.sv
module sts_pair
    import sts_pkg::*;
#(
    parameter int PTR_W  = 3,
    parameter int PAGE_W = 9,
    parameter int OFS_W  = 7,
    localparam int W0    = PTR_W + 4 + PAGE_W,
    localparam int W1    = PTR_W + P1_LOW,
    localparam int AW    = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st0_ld,
    input  logic [W0-1:0]     st0_data,
    input  logic              st1_ld,
    input  logic [W1-1:0]     st1_data,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              page_ld,
    input  logic [PAGE_W-1:0] page_val,
    input  logic [3:0]        mode_op,
    input  logic              mode_arg,
    input  logic [1:0]        pm_val,
    input  logic              ovf_evt,
    input  logic              ovf_clr,
    input  logic              int_ack,
    input  logic              int_dis,
    input  logic              int_en,
    input  logic              tc_we,
    input  logic              tc_val,
    input  logic              c_we,
    input  logic              c_val,
    input  logic [OFS_W-1:0]  ofs,
    output logic [W0-1:0]     st0_word,
    output logic [W1-1:0]     st1_word,
    output logic [PTR_W-1:0]  arp_o,
    output logic [PTR_W-1:0]  arb_o,
    output logic [PAGE_W-1:0] dp_o,
    output logic              ov_o,
    output logic              ovm_o,
    output logic              intm_o,
    output logic              cnf_o,
    output logic              tc_o,
    output logic              sxm_o,
    output logic              c_o,
    output logic              hm_o,
    output logic              fsm_o,
    output logic              xf_o,
    output logic              fo_o,
    output logic              txm_o,
    output logic [1:0]        pm_o,
    output logic [AW-1:0]     dir_addr
);
    localparam int OVM_B  = PAGE_W + 2;
    localparam int PTR_L0 = W0 - PTR_W;

    logic [12:0] d1_low;
    logic        unused_bits;

    assign d1_low      = st1_data[P1_LOW-1:0];
    assign unused_bits = ^{st0_data[PAGE_W+3], st0_data[PAGE_W+1:PAGE_W], d1_low[8:7]};

    sts_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk (clk),
        .rst_n (rst_n),
        .ld1 (st1_ld),
        .ld0 (st0_ld),
        .ld  (ptr_ld),
        .v1  (st1_data[W1-1:P1_LOW]),
        .v0  (st0_data[W0-1:PTR_L0]),
        .v   (ptr_val),
        .arp (arp_o),
        .arb (arb_o)
    );

    sts_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld0     (st0_ld),
        .ld1     (st1_ld),
        .d1_tc   (d1_low[P1_TC]),
        .d1_c    (d1_low[P1_C]),
        .ovf_evt (ovf_evt),
        .ovf_clr (ovf_clr),
        .int_ack (int_ack),
        .int_dis (int_dis),
        .int_en  (int_en),
        .tc_we   (tc_we),
        .tc_val  (tc_val),
        .c_we    (c_we),
        .c_val   (c_val),
        .ov      (ov_o),
        .intm    (intm_o),
        .tc      (tc_o),
        .c       (c_o)
    );

    sts_modes #(.PAGE_W(PAGE_W)) u_modes (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld0      (st0_ld),
        .d0_ovm   (st0_data[OVM_B]),
        .d0_dp    (st0_data[PAGE_W-1:0]),
        .ld1      (st1_ld),
        .d1_low   (d1_low),
        .op       (mode_op),
        .arg      (mode_arg),
        .pm_arg   (pm_val),
        .page_ld  (page_ld),
        .page_val (page_val),
        .ovm      (ovm_o),
        .dp       (dp_o),
        .cnf      (cnf_o),
        .sxm      (sxm_o),
        .hm       (hm_o),
        .fsm      (fsm_o),
        .xf       (xf_o),
        .fo       (fo_o),
        .txm      (txm_o),
        .pm       (pm_o)
    );

    assign st0_word = {arp_o, ov_o, ovm_o, 1'b1, intm_o, dp_o};
    assign st1_word = {arb_o, cnf_o, tc_o, sxm_o, c_o, 2'b11,
                       hm_o, fsm_o, xf_o, fo_o, txm_o, pm_o};
    assign dir_addr = {dp_o, ofs};
endmodule

// File: rtl/sts_pair_chk.sv
module sts_pair_chk #(
    parameter int PTR_W = 3,
    parameter int W1    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st0_ld,
    input logic             st1_ld,
    input logic [W1-1:0]    st1_data,
    input logic             ptr_ld,
    input logic [PTR_W-1:0] ptr_val,
    input logic             ovf_evt,
    input logic             ovf_clr,
    input logic             int_ack,
    input logic             int_dis,
    input logic             int_en,
    input logic [PTR_W-1:0] arp_o,
    input logic [PTR_W-1:0] arb_o,
    input logic             ov_o,
    input logic             intm_o
);
    p_ptr_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_ld && !st0_ld && !st1_ld) |=> (arb_o == $past(arp_o) && arp_o == $past(ptr_val)));

    p_rest0_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st0_ld && !int_ack && !int_dis && !int_en) |=> (intm_o == $past(intm_o)));

    p_rest0_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st0_ld && !st1_ld) |=> $stable(arb_o));

    p_rest1_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st1_ld |=> (arp_o == arb_o && arb_o == $past(st1_data[W1-1:W1-PTR_W])));

    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack || int_dis) |=> intm_o);

    p_ov_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ov_o);

    p_ov_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_o && !ovf_clr && !st0_ld) |=> ov_o);
endmodule

bind sts_pair sts_pair_chk #(.PTR_W(PTR_W), .W1(W1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st0_ld   (st0_ld),
    .st1_ld   (st1_ld),
    .st1_data (st1_data),
    .ptr_ld   (ptr_ld),
    .ptr_val  (ptr_val),
    .ovf_evt  (ovf_evt),
    .ovf_clr  (ovf_clr),
    .int_ack  (int_ack),
    .int_dis  (int_dis),
    .int_en   (int_en),
    .arp_o    (arp_o),
    .arb_o    (arb_o),
    .ov_o     (ov_o),
    .intm_o   (intm_o)
);

// File: tb/tb_sts_pair.sv
module tb_sts_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st0_ld = 0, st1_ld = 0, ptr_ld = 0, page_ld = 0;
    logic [15:0] st0_data = '0, st1_data = '0;
    logic [2:0]  ptr_val = '0;
    logic [8:0]  page_val = '0;
    logic [3:0]  mode_op = '0;
    logic        mode_arg = 0;
    logic [1:0]  pm_val = '0;
    logic        ovf_evt = 0, ovf_clr = 0, int_ack = 0, int_dis = 0, int_en = 0;
    logic        tc_we = 0, tc_val = 0, c_we = 0, c_val = 0;
    logic [6:0]  ofs = '0;
    logic [15:0] st0_word, st1_word, dir_addr;
    logic [2:0]  arp_o, arb_o;
    logic [8:0]  dp_o;
    logic        ov_o, ovm_o, intm_o, cnf_o, tc_o, sxm_o, c_o, hm_o, fsm_o, xf_o, fo_o, txm_o;
    logic [1:0]  pm_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sts_pair dut (.*);

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        st0_ld = 0; st1_ld = 0; ptr_ld = 0; page_ld = 0;
        mode_op = '0; mode_arg = 0; ovf_evt = 0; ovf_clr = 0;
        int_ack = 0; int_dis = 0; int_en = 0; tc_we = 0; c_we = 0;
    endtask

    task automatic t_reset();
        chk("R1 st0", 32'(st0_word), 32'h0600);
        chk("R1 st1", 32'(st1_word), 32'h07F0);
        chk("R1 intm", 32'(intm_o), 1);
    endtask

    task automatic t_pointer();
        ptr_ld = 1; ptr_val = 3'd5; step(); idle();
        chk("R4 arp", 32'(arp_o), 5);
        chk("R4 arb", 32'(arb_o), 0);
        ptr_ld = 1; ptr_val = 3'd2; step(); idle();
        chk("R4 arp2", 32'(arp_o), 2);
        chk("R4 arb2", 32'(arb_o), 5);
        chk("R2 st0 pointer field", 32'(st0_word[15:13]), 2);
        chk("R3 st1 buffer field", 32'(st1_word[15:13]), 5);
    endtask

    task automatic t_restore0();
        ovf_evt = 1; step(); idle();
        st0_ld = 1; st0_data = {3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1A5}; step(); idle();
        chk("R5 arp", 32'(arp_o), 6);
        chk("R5 arb kept", 32'(arb_o), 5);
        chk("R5 intm kept", 32'(intm_o), 1);
        chk("R8 ov cleared by restore", 32'(ov_o), 0);
        chk("R2 st0 word", 32'(st0_word), 32'({3'd6, 1'b0, 1'b1, 1'b1, 1'b1, 9'h1A5}));
    endtask

    task automatic t_restore1();
        st1_ld = 1;
        st1_data = {3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10};
        step(); idle();
        chk("R6 arp", 32'(arp_o), 3);
        chk("R6 arb", 32'(arb_o), 3);
        chk("R3 st1 word", 32'(st1_word),
            32'({3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10}));
        chk("R6 pm", 32'(pm_o), 2);
    endtask

    task automatic t_intm();
        int_en = 1; step(); idle();
        chk("R7 enable", 32'(intm_o), 0);
        int_en = 1; int_dis = 1; step(); idle();
        chk("R7 disable wins", 32'(intm_o), 1);
        int_en = 1; step(); idle();
        int_en = 1; int_ack = 1; step(); idle();
        chk("R7 ack wins", 32'(intm_o), 1);
        int_en = 1; step(); idle(); step();
        chk("R7 hold clear", 32'(intm_o), 0);
    endtask

    task automatic t_ov();
        ovf_evt = 1; step(); idle();
        chk("R8 set", 32'(ov_o), 1);
        step();
        chk("R8 sticky", 32'(ov_o), 1);
        ovf_clr = 1; step(); idle();
        chk("R8 branch clear", 32'(ov_o), 0);
        ovf_evt = 1; ovf_clr = 1; step(); idle();
        chk("R8 set beats clear", 32'(ov_o), 1);
        st0_ld = 1; st0_data = {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 9'h1A5}; ovf_evt = 1; step(); idle();
        chk("R8 set beats restore", 32'(ov_o), 1);
        st0_ld = 1; step(); idle();
        chk("R8 restore ignores ov bit", 32'(ov_o), 0);
    endtask

    task automatic t_modes();
        mode_op = 4'd1; mode_arg = 1; step(); idle();
        chk("R9 ovm", 32'(ovm_o), 1);
        mode_op = 4'd3; mode_arg = 1; step();
        mode_op = 4'd7; step();
        mode_op = 4'd8; step();
        mode_op = 4'd5; step();
        mode_arg = 0;
        mode_op = 4'd6; step();
        mode_op = 4'd4; step();
        mode_op = 4'd2; step();
        mode_op = 4'd9; pm_val = 2'b01; step();
        mode_op = 4'd0; mode_arg = 1; pm_val = 2'b11; step(); idle();
        chk("R9 st1 after commands", 32'(st1_word),
            32'({3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01}));
    endtask

    task automatic t_units();
        c_we = 1; c_val = 1; tc_we = 1; tc_val = 0; step(); idle();
        chk("R10 carry", 32'(c_o), 1);
        chk("R10 tc", 32'(tc_o), 0);
    endtask

    task automatic t_addr();
        page_ld = 1; page_val = 9'h0F3; step(); idle();
        ofs = 7'h55; #1;
        chk("R11 addr", 32'(dir_addr), 32'({9'h0F3, 7'h55}));
    endtask

    task automatic t_prio();
        st1_ld = 1; st1_data = {3'd4, 13'h0000}; mode_op = 4'd3; mode_arg = 1; c_we = 1; c_val = 1;
        step(); idle();
        chk("R12 sxm restore wins", 32'(sxm_o), 0);
        chk("R12 carry restore wins", 32'(c_o), 0);
        st1_ld = 1; st0_ld = 1; ptr_ld = 1; ptr_val = 3'd1;
        st1_data = {3'd2, 13'h0000}; st0_data = {3'd7, 4'b0000, 9'h011};
        step(); idle();
        chk("R13 st1 first arp", 32'(arp_o), 2);
        chk("R13 st1 first arb", 32'(arb_o), 2);
        st0_ld = 1; ptr_ld = 1; ptr_val = 3'd1; page_ld = 1; page_val = 9'h0FF; step(); idle();
        chk("R13 st0 over load", 32'(arp_o), 7);
        chk("R13 buffer untouched", 32'(arb_o), 2);
        chk("R12 dp restore wins", 32'(dp_o), 32'h011);
    endtask

    initial begin
        step(); step();
        rst_n = 1;
        t_reset();
        t_pointer();
        t_restore0();
        t_restore1();
        t_intm();
        t_ov();
        t_modes();
        t_units();
        t_addr();
        t_prio();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #80000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule